// File: doc/BRIEF.md
# GPIO controller with edge interrupts

This block gives software control over 32 general-purpose pins, arranged as two banks of 16, through a small 32-bit register bus. Each pin can be an input or an output. Output levels change only through write-one set and clear registers, never through a read-modify-write. Every pin can be read back through a two-flop synchronizer, whether it is an input or an output. Each pin can raise an interrupt on a rising edge, on a falling edge, or on both. Each edge enable has its own write-one set and clear register.

A detected edge that is enabled latches a bit in a write-one-to-clear status register. Bits 15:0 of every register belong to bank 0 and bits 31:16 to bank 1, so pin n sits at bank n/16, bit n%16. Each bank drives its own level interrupt line. That line is high while any of the bank's status bits is pending and the bank's enable bit is set.

The register bus is a control path with no handshake. A write is taken on any clock edge where the write enable is high. The read data is a combinational function of the address. Because no data stream crosses the block's edge, no valid/ready interface is needed and no back-pressure rules apply.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0). `pin_out` is 0, all edge enables are off, status reads 0, both bank enables read 0, `bank_irq` is 0, and the direction register reads 0xFFFFFFFF.
- R2: The direction register at 0x10 is read/write. A bit at 1 makes the pin an input and a bit at 0 makes it an output, so `pin_oe` is the inverse of the register value from the clock edge after the write.
- R3: A write to 0x18 drives the pins whose mask bit is 1 high, and a write to 0x1C drives them low. Pins whose mask bit is 0 keep their level. Register 0x14 reads the output latch.
- R4: Register 0x20 returns the pin level sampled through two flops, whether the pin is an input or an output. A change at `pin_in` is readable after the second rising clock edge.
- R5: The rising-edge enable is set by writing 1s to 0x24 and cleared by writing 1s to 0x28. The falling-edge enable is set at 0x2C and cleared at 0x30. Both enables may be on for the same pin. All four of these registers read as zero.
- R6: A status bit is set only when an enabled edge occurs on its pin. The bit is readable, and drives `bank_irq`, after the third rising clock edge following the change at `pin_in`. An edge whose enable is off sets nothing.
- R7: Writing 1 to a bit of the status register at 0x34 clears that bit, and a 0 leaves it unchanged. If an enabled edge arrives in the same cycle as the clear write, the bit stays set.
- R8: Register bits 15:0 belong to bank 0 and bits 31:16 to bank 1. Pin n maps to bank n/16, bit n%16, and only that bank's interrupt line reflects it.
- R9: `bank_irq[b]` is 1 exactly when bank b has a pending status bit and bit b of the bank enable register at 0x08 (read/write) is 1.
- R10: Unmapped addresses read as zero. Writes to the read-only registers at 0x14 and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output latch levels |
| pin_oe | output | 32 | Output drive enable, 1 = drive |
| bank_irq | output | 2 | Level interrupt per bank |

## Verification
The assertions assume that `bus_wdata` and `bus_addr` are known whenever `bus_we` is high. They also assume that reset is held for at least one clock edge, so that every past value they compare against is a reset value or a later one. The stimulus changes bus inputs and pin levels only on falling clock edges. It holds each pin level for at least three rising edges before the next change, so every transition passes through the synchronizer and is seen as exactly one edge. The single deliberate exception places a status-clear write in the same cycle as a new edge, to exercise the case where the edge wins.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT      = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_IN       = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h34;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;

  // R4: the synchronized level is the raw pin delayed by two edges
  a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (level_o == $past(pins_i, 2)));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic         en_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] wipe;

  assign wipe = clr_i ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~wipe) | hit_i;
  end

  assign status_o = status_q;
  assign irq_o    = en_i & (|status_q);

  // R6: every enabled edge is latched on the next edge
  a_r6_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((status_q & $past(hit_i)) == $past(hit_i)));
  // R6: no status bit appears without an edge
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status_q & ~$past(status_q) & ~$past(hit_i)) == '0));
  // R7: cleared bits without a concurrent edge drop
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((status_q & $past(clr_mask_i & ~hit_i)) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic                                 bus_we,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]   bus_wdata,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   bus_rdata,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_oe,
  output logic [NUM_BANKS-1:0]                 bank_irq
);
  localparam int NPINS = NUM_BANKS * PINS_PER_BANK;

  logic [NPINS-1:0]     dir_q, out_q, rise_en_q, fall_en_q;
  logic [NUM_BANKS-1:0] bank_en_q;
  logic [NPINS-1:0]     level, rise, fall, hit, status_all;
  logic                 wr_status;

  function automatic logic wr_at(input logic [ADDR_W-1:0] ofs);
    return bus_we && (bus_addr == ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      bank_en_q <= '0;
    end else begin
      if (wr_at(OFS_DIR))      dir_q     <= bus_wdata;
      if (wr_at(OFS_BANK_EN))  bank_en_q <= bus_wdata[NUM_BANKS-1:0];
      if (wr_at(OFS_OUT_SET))  out_q     <= out_q | bus_wdata;
      if (wr_at(OFS_OUT_CLR))  out_q     <= out_q & ~bus_wdata;
      if (wr_at(OFS_RISE_SET)) rise_en_q <= rise_en_q | bus_wdata;
      if (wr_at(OFS_RISE_CLR)) rise_en_q <= rise_en_q & ~bus_wdata;
      if (wr_at(OFS_FALL_SET)) fall_en_q <= fall_en_q | bus_wdata;
      if (wr_at(OFS_FALL_CLR)) fall_en_q <= fall_en_q & ~bus_wdata;
    end
  end

  assign pin_out   = out_q;
  assign pin_oe    = ~dir_q;
  assign wr_status = wr_at(OFS_STATUS);

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_i  (pin_in),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign hit = (rise & rise_en_q) | (fall & fall_en_q);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_irq #(.W(PINS_PER_BANK)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .clr_i      (wr_status),
      .clr_mask_i (bus_wdata[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .en_i       (bank_en_q[b]),
      .status_o   (status_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .irq_o      (bank_irq[b])
    );

    // R9: a bank line never rises while its bank is disabled
    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      bank_irq[b] |-> (bank_en_q[b] && (status_all[b*PINS_PER_BANK +: PINS_PER_BANK] != '0)));
  end

  always_comb begin
    unique case (bus_addr)
      OFS_BANK_EN: bus_rdata = {{(NPINS-NUM_BANKS){1'b0}}, bank_en_q};
      OFS_DIR:     bus_rdata = dir_q;
      OFS_OUT:     bus_rdata = out_q;
      OFS_IN:      bus_rdata = level;
      OFS_STATUS:  bus_rdata = status_all;
      default:     bus_rdata = '0;
    endcase
  end

  // R2: drive enable follows the written direction
  a_r2_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
    wr_at(OFS_DIR) |=> (pin_oe == ~$past(bus_wdata)));
  // R3: set-write raises masked bits, leaves others alone
  a_r3_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_at(OFS_OUT_SET) |=> (((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
                            ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata)))));
  // R3: clear-write lowers masked bits, leaves others alone
  a_r3_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_at(OFS_OUT_CLR) |=> (((pin_out & $past(bus_wdata)) == '0) &&
                            ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata)))));
  // R10: writes to read-only registers leave the outputs unchanged
  a_r10_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_at(OFS_OUT) || wr_at(OFS_IN)) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic [1:0]  bank_irq;
  logic [31:0] ext_lvl = '0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, model, mask, exp;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 bank_irq", {30'h0, bank_irq}, 32'h0);
    rd(8'h34, r); check("R1 status", r, 32'h0);
    rd(8'h08, r); check("R1 bank enable", r, 32'h0);
    rd(8'h10, r); check("R1 direction", r, 32'hFFFF_FFFF);

    // R2 direction
    wr(8'h10, 32'h0000_FFFF);
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(8'h10, r); check("R2 dir readback", r, 32'h0000_FFFF);

    // R3 set/clear sweep with arithmetic model
    model = '0;
    for (int k = 0; k < 12; k++) begin
      mask = 32'h9E37_79B9 * (k + 1) ^ (32'h1 << k);
      if (k[0]) begin wr(8'h1C, mask); model = model & ~mask; end
      else      begin wr(8'h18, mask); model = model | mask; end
      check("R3 pin_out", pin_out, model);
    end
    rd(8'h14, r); check("R3 readback", r, model);

    // R4 input readback, mixed directions
    ext_lvl = 32'h1234_ABCD;
    settle();
    rd(8'h20, r);
    check("R4 input data", r, (pin_oe & model) | (~pin_oe & ext_lvl));
    @(negedge clk) ext_lvl = 32'hF0F0_0F0F;
    @(posedge clk);
    #1 check("R4 not yet after one edge", u0.bus_rdata, (pin_oe & model) | (~pin_oe & 32'h1234_ABCD));
    @(posedge clk);
    #1 check("R4 visible after two edges", bus_rdata, (pin_oe & model) | (~pin_oe & 32'hF0F0_0F0F));

    // R10 read-only writes and unmapped reads
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R10 ro write", pin_out, model);
    rd(8'h00, r); check("R10 unmapped 0x00", r, 32'h0);
    rd(8'h3C, r); check("R10 unmapped 0x3C", r, 32'h0);

    // back to all inputs, quiet pins
    wr(8'h10, 32'hFFFF_FFFF);
    ext_lvl = '0;
    settle();
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h08, 32'h3);
    rd(8'h08, r); check("R9 bank enable readback", r, 32'h3);

    // R5 write-only enables read zero
    wr(8'h24, 32'hFFFF_FFFF);
    for (int a = 0; a < 4; a++) begin
      rd(8'h24 + 8'(a * 4), r); check("R5 write-only reads zero", r, 32'h0);
    end

    // R5 R6 R8 sweep: every pin x every enable mode
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        mask = 32'h1 << p;
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        if (m[0]) wr(8'h24, mask);
        if (m[1]) wr(8'h2C, mask);
        @(negedge clk) ext_lvl = mask;
        settle();
        exp = m[0] ? mask : 32'h0;
        rd(8'h34, r); check("R6 rising edge status", r, exp);
        check("R8 bank line rise", {30'h0, bank_irq}, m[0] ? (32'h1 << (p / 16)) : 32'h0);
        wr(8'h34, mask);
        @(negedge clk) ext_lvl = '0;
        settle();
        exp = m[1] ? mask : 32'h0;
        rd(8'h34, r); check("R6 falling edge status", r, exp);
        check("R8 bank line fall", {30'h0, bank_irq}, m[1] ? (32'h1 << (p / 16)) : 32'h0);
        wr(8'h34, mask);
        rd(8'h34, r); check("R7 cleared", r, 32'h0);
      end
    end

    // R7 zero bits keep, edge wins over clear
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h24, 32'h0011_0002);
    @(negedge clk) ext_lvl = 32'h0001_0002;
    settle();
    wr(8'h34, 32'h0000_0002);
    rd(8'h34, r); check("R7 zero bits keep", r, 32'h0001_0000);
    wr(8'h34, 32'hFFFF_FFFF);
    @(negedge clk) ext_lvl = 32'h0011_0002;
    @(posedge clk);
    @(posedge clk);
    wr(8'h34, 32'h0010_0000);
    rd(8'h34, r); check("R7 edge wins", r, 32'h0010_0000);

    // R9 bank gating
    wr(8'h08, 32'h1);
    check("R9 bank1 gated", {30'h0, bank_irq}, 32'h0);
    wr(8'h08, 32'h2);
    check("R9 bank1 enabled", {30'h0, bank_irq}, 32'h2);
    wr(8'h34, 32'hFFFF_FFFF);
    check("R9 drops when clear", {30'h0, bank_irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule